// File: doc/BRIEF.md
# Run-Length Group-Code Serial Encoder

This block turns a serial bit stream into a variable-length run-length code. It counts consecutive zeros until a one arrives. It then places that run length l into a group j, and shifts out a codeword of 2j bits. The codeword is a j-bit prefix that names the group, followed by a j-bit tail that picks the member within the group. Short runs, which are the most common ones in scan test data, get the shortest codewords. Each further group doubles the number of run lengths it covers and adds two bits to the codeword.

The encoder takes one input bit per handshake. It holds its ready signal low while a codeword is on the output. An end-of-stream strobe flushes a trailing run of zeros that no one has terminated. That codeword is marked with a pad flag, so the consumer knows to drop the implied final one after decoding. Runs longer than the largest group can hold saturate, and a sticky error flag is raised. The block mainly produces stimulus for a matching decoder and closes a round-trip check against it.

Top module: `rlg_encoder`

## Requirements
- R1: An accepted zero (in_valid and in_ready high, in_bit 0) lengthens the pending run and produces no output bit.
- R2: An accepted one ends the pending run of length l. The run goes to group j = floor(log2(l+2)), so l=0 and 1 give j=1, l=2..5 give j=2, and l=6..13 give j=3. A codeword of exactly 2j bits follows, starting the cycle after the accept.
- R3: The first j bits of the codeword are the prefix: j-1 ones then a single zero, sent first.
- R4: The last j bits are the tail. The tail is the value l+2-2^j, sent most significant bit first. Examples: l=0 gives 00, and l=8 gives 110010.
- R5: out_valid is high on exactly the codeword bits, one bit per cycle. out_last is high only on the final bit of each codeword.
- R6: in_ready is low on every cycle in which out_valid is high. Input is accepted again only after the codeword has been fully sent.
- R7: An eos strobe with in_ready high, in_valid low and a pending run l>0 emits the codeword for l, as if a one had ended the run. out_pad is high on every bit of that codeword. If in_valid is high in the same cycle, eos is ignored.
- R8: An eos strobe with no pending zeros produces no output.
- R9: A run saturates at 2^(MAX_GROUP+1)-3, which is 2045 by default and the last member of the largest group. A further zero leaves the count unchanged and sets ovf_err. ovf_err stays high until reset.
- R10: After reset, in_ready is 1, out_valid is 0 and ovf_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit present |
| in_bit | input | 1 | Input data bit |
| in_ready | output | 1 | Encoder can take an input bit or eos |
| eos | input | 1 | End-of-stream strobe, flushes a pending run |
| out_valid | output | 1 | out_bit carries a codeword bit |
| out_bit | output | 1 | Serial codeword bit |
| out_last | output | 1 | Final bit of the current codeword |
| out_pad | output | 1 | Current codeword comes from a flush; the decoded trailing one is not real |
| ovf_err | output | 1 | Sticky run-length saturation error |

## Verification
The saturation path is the hardest to reach from the ports. It needs more than two thousand zeros in a row before the counter reaches its ceiling. The bench streams 2046 zeros to get there. It then terminates the run and checks the largest-group codeword together with the sticky error. The flush path also needs a specific ordering: a trailing run, then eos on an idle input cycle. The bench covers this both with a pending run and with an empty one.

// File: rtl/rlg_encoder.sv
module rlg_encoder #(
  parameter int MAX_GROUP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  input  logic eos,
  output logic out_valid,
  output logic out_bit,
  output logic out_last,
  output logic out_pad,
  output logic ovf_err
);
  localparam int RUN_W = MAX_GROUP + 1;
  localparam int GW = $clog2(MAX_GROUP + 1);
  localparam int PW = GW + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'((1 << (MAX_GROUP + 1)) - 3);

  logic             busy, pad_r;
  logic [RUN_W-1:0] run_cnt, val;
  logic [GW-1:0]    grp;
  logic [PW-1:0]    pos;

  function automatic logic [GW-1:0] top_bit(input logic [RUN_W-1:0] v);
    top_bit = '0;
    for (int i = 0; i < RUN_W; i++)
      if (v[i]) top_bit = GW'(i);
  endfunction

  logic             take, term, flush, start;
  logic [RUN_W-1:0] nxt_val;
  assign in_ready = !busy;
  assign take     = in_valid && in_ready;
  assign term     = take && in_bit;
  assign flush    = in_ready && !in_valid && eos && (run_cnt != '0);
  assign start    = term || flush;
  assign nxt_val  = run_cnt + RUN_W'(2);

  logic [PW-1:0]    grp_p, len_m1, tidx;
  logic [RUN_W-1:0] sh;
  assign grp_p  = PW'(grp);
  assign len_m1 = (grp_p << 1) - PW'(1);
  assign tidx   = len_m1 - pos;
  assign sh     = val >> tidx;

  assign out_valid = busy;
  assign out_last  = busy && (pos == len_m1);
  assign out_pad   = busy && pad_r;
  assign out_bit   = busy && ((pos < grp_p) ? (pos < grp_p - PW'(1)) : sh[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pad_r   <= 1'b0;
      run_cnt <= '0;
      val     <= '0;
      grp     <= '0;
      pos     <= '0;
      ovf_err <= 1'b0;
    end else if (busy) begin
      if (out_last) busy <= 1'b0;
      else          pos  <= pos + PW'(1);
    end else if (start) begin
      busy    <= 1'b1;
      pos     <= '0;
      val     <= nxt_val;
      grp     <= top_bit(nxt_val);
      pad_r   <= flush;
      run_cnt <= '0;
    end else if (take) begin
      if (run_cnt == RUN_MAX) ovf_err <= 1'b1;
      else                    run_cnt <= run_cnt + RUN_W'(1);
    end
  end
endmodule

// File: rtl/rlg_encoder_chk.sv
module rlg_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_bit,
  input logic in_ready,
  input logic eos,
  input logic out_valid,
  input logic out_last,
  input logic out_pad,
  input logic ovf_err
);
  p_zero_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_bit) |=> !out_valid);

  p_one_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_bit) |=> out_valid);

  p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_ready_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_pad_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_pad |-> out_valid);

  p_pad_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> $stable(out_pad));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

bind rlg_encoder rlg_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
  .in_ready(in_ready), .eos(eos), .out_valid(out_valid),
  .out_last(out_last), .out_pad(out_pad), .ovf_err(ovf_err)
);

// File: tb/rlg_encoder_bench.sv
`timescale 1ns/1ps
module rlg_encoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, eos = 1'b0;
  logic in_ready, out_valid, out_bit, out_last, out_pad, ovf_err;

  always #2.5 clk = ~clk;

  rlg_encoder u_rlg_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .eos(eos), .out_valid(out_valid), .out_bit(out_bit),
    .out_last(out_last), .out_pad(out_pad), .ovf_err(ovf_err)
  );

  int n_chk = 0, n_fail = 0, n_last = 0, n_pad = 0, n_rdy_bad = 0;
  bit done = 0;
  bit cap[$];
  bit exp_q[$];

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      cap.push_back(out_bit);
      if (out_last) n_last++;
      if (out_pad) n_pad++;
      if (in_ready) n_rdy_bad++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int grp_of(input int l);
    int j = 1;
    while ((1 << (j + 1)) <= l + 2) j++;
    return j;
  endfunction

  function automatic void push_code(input int l);
    int j = grp_of(l);
    int t = l + 2 - (1 << j);
    for (int i = 0; i < j - 1; i++) exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    for (int k = j - 1; k >= 0; k--) exp_q.push_back(1'((t >> k) & 1));
  endfunction

  function automatic string bits_str(input bit q[$]);
    string s = "";
    foreach (q[i]) s = $sformatf("%s%0d", s, q[i]);
    return s;
  endfunction

  task automatic cmp_stream(input string req);
    n_chk++;
    if (cap != exp_q) begin
      n_fail++;
      $display("FAIL %s stream: actual %s expected %s", req, bits_str(cap), bits_str(exp_q));
    end
  endtask

  task automatic clear();
    cap.delete(); exp_q.delete(); n_last = 0; n_pad = 0; n_rdy_bad = 0;
  endtask

  task automatic put(input bit b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_bit = b;
    @(negedge clk);
    in_valid = 1'b0; in_bit = 1'b0;
  endtask

  task automatic run(input int l);
    for (int i = 0; i < l; i++) put(1'b0);
    put(1'b1);
  endtask

  task automatic strobe_eos();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    eos = 1'b1;
    @(negedge clk);
    eos = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (out_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10", "in_ready", int'(in_ready), 1);
    check("R10", "out_valid", int'(out_valid), 0);
    check("R10", "ovf_err", int'(ovf_err), 0);
  endtask

  task automatic t_single_one();
    clear(); run(0); drain(); push_code(0);
    cmp_stream("R2 l=0 code 00");
    check("R5", "out_last count", n_last, 1);
  endtask

  task automatic t_run8();
    clear(); run(8); drain(); push_code(8);
    cmp_stream("R3 R4 l=8 code 110010");
  endtask

  task automatic t_zero_silent();
    clear();
    for (int i = 0; i < 3; i++) put(1'b0);
    repeat (4) @(negedge clk);
    check("R1", "bits after zeros", cap.size(), 0);
    put(1'b1); drain(); push_code(3);
    cmp_stream("R1 l=3");
  endtask

  task automatic t_mixed();
    int lens[6] = '{1, 2, 5, 6, 13, 30};
    clear();
    foreach (lens[i]) begin run(lens[i]); push_code(lens[i]); end
    drain();
    cmp_stream("R2 mixed groups");
    check("R5", "out_last count", n_last, 6);
    check("R6", "ready high during output", n_rdy_bad, 0);
  endtask

  task automatic t_eos();
    clear();
    for (int i = 0; i < 4; i++) put(1'b0);
    strobe_eos(); drain(); push_code(4);
    cmp_stream("R7 flush l=4");
    check("R7", "out_pad bits", n_pad, 4);
  endtask

  task automatic t_eos_empty();
    clear();
    strobe_eos(); repeat (6) @(negedge clk);
    check("R8", "bits after empty eos", cap.size(), 0);
  endtask

  task automatic t_overflow();
    clear();
    for (int i = 0; i < 2045; i++) put(1'b0);
    check("R9", "ovf_err at ceiling", int'(ovf_err), 0);
    put(1'b0);
    check("R9", "ovf_err after extra zero", int'(ovf_err), 1);
    put(1'b1); drain(); push_code(2045);
    cmp_stream("R9 saturated code");
    check("R9", "ovf_err sticky", int'(ovf_err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_one();
    t_run8();
    t_zero_silent();
    t_mixed();
    t_eos();
    t_eos_empty();
    t_overflow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule